// File: doc/BRIEF.md
# Segmented and Paged Address Translator

This block turns the virtual address of one memory access into a physical address. It looks at the operating mode first. In real mode the address passes straight through. In protected mode the selected segment adds its base and checks its permissions and limit. When paging is on, a small fully associative translation cache turns the linear address into a physical one. A request either produces a physical address or returns a two-bit fault code. The code reports a segment protection violation or a cache miss. On a miss, a page walker outside this block must resolve the address.

The walker fills the cache through an insert port. Each insert gives a virtual page, a physical page and a page size of 4 KB, 2 MB or 4 MB. On a hit, the offset bits kept from the linear address follow the page size stored in the matching entry. Inserts take free entries first. Once the cache is full, each insert overwrites the entry that was inserted longest ago. A flush input empties the whole cache in one cycle.

The result is registered, so each response appears exactly one clock after its request.

Top module: `addr_xlate`

## Requirements
- R1: The response appears one cycle after the request. `rsp_valid` is high in the cycle after `req_valid` was high. In any cycle where `rsp_valid` is low, `rsp_fault` is 00 and `rsp_pa` is 0. Both of these also hold after reset.
- R2: `rsp_fault` uses three codes: 00 for no fault, 01 for a general-protection fault and 10 for a translation miss. The value 11 never appears.
- R3: When `pe` is low, `rsp_pa` equals `req_va` with fault 00. This holds whatever the segment inputs, `pg` and `req_write` are.
- R4: The segment checks apply when `pe` is high and the access is not in 64-bit mode. In that case, a write to a segment whose `seg_writable` is low gives fault 01.
- R5: For a normal segment (`seg_expdown` low) with checks applied, an offset above `seg_limit` gives fault 01. An offset equal to the limit is allowed.
- R6: For an expand-down segment with checks applied, an offset at or below `seg_limit` gives fault 01. An offset above the limit is allowed.
- R7: The access is in 64-bit mode only when both `lma` and `cs_long` are high. In 64-bit mode the write-permission check and the limit check are both skipped.
- R8: In protected mode the linear address is `seg_base + req_va`, wrapping modulo 2^ADDR_W. When `pg` is low, `rsp_pa` is that linear address with fault 00.
- R9: When paging is on and no valid entry matches, the fault is 10 and `rsp_pa` carries the linear address for the walker.
- R10: Page-size codes are 0 for 4 KB, 1 for 2 MB, 2 for 4 MB, and 3 for 4 KB. An entry matches when the linear address, with its offset bits cleared, equals the stored page. A hit returns the stored physical page ORed with the linear offset bits. Both the stored page and the physical page are cleared below the page size when they are inserted.
- R11: An insert fills the free entry with the lowest index. When all ENTRIES entries are valid, an insert replaces the entry that was inserted least recently.
- R12: A flush invalidates every entry. A flush overrides an insert made in the same cycle. An insert is visible to requests from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | ADDR_W | Virtual address (segment offset) |
| req_write | input | 1 | Access is a write |
| pe | input | 1 | Protected mode enable |
| pg | input | 1 | Paging enable |
| lma | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment runs 64-bit code |
| seg_base | input | ADDR_W | Selected segment base |
| seg_limit | input | ADDR_W | Selected segment limit |
| seg_writable | input | 1 | Selected segment allows writes |
| seg_expdown | input | 1 | Selected segment grows downward |
| ins_valid | input | 1 | Insert a translation |
| ins_va | input | ADDR_W | Virtual page of insert |
| ins_pa | input | ADDR_W | Physical page of insert |
| ins_size | input | 2 | Page size code of insert |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | ADDR_W | Physical address, or linear address on a miss |
| rsp_fault | output | 2 | Fault code |

## Verification
The cache state can only be observed through lookups. A bad valid bit, a stale page or a wrong size code appears as a miss where a hit was expected, or as a wrong physical address. Either shows up on the response one cycle after the lookup that touches the entry. A broken allocator or victim pointer stays hidden until the cache has been full for an insert or two. At that point the wrong entry starts to miss, so the bench fills the cache completely and then probes every page after each replacement. Errors in the mode and segment checks are stateless and show up on the very next response.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_MISS = 2'b10
  } flt_e;

  // Offset mask for a page-size code; callers slice to their width.
  function automatic logic [63:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd1:    page_mask = 64'h0000_0000_001F_FFFF;
      2'd2:    page_mask = 64'h0000_0000_003F_FFFF;
      default: page_mask = 64'h0000_0000_0000_0FFF;
    endcase
  endfunction

endpackage

// File: rtl/xlt_segchk.sv
`timescale 1ns/1ps
module xlt_segchk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic              is_write,
  input  logic              long64,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              writable,
  input  logic              expdown,
  output logic [ADDR_W-1:0] linear,
  output logic              gp
);

  logic wr_bad;
  logic lim_bad;

  assign linear = offset + base;

  always_comb begin
    wr_bad  = is_write && !writable;
    if (expdown) lim_bad = (offset <= limit);
    else         lim_bad = (offset > limit);
    gp = !long64 && (wr_bad || lim_bad);
  end

endmodule

// File: rtl/xlt_tlb.sv
`timescale 1ns/1ps
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_pa,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_va,
  input  logic [ADDR_W-1:0] ins_pa,
  input  logic [1:0]        ins_size,
  input  logic              flush
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ADDR_W-1:0]  tag_mem  [ENTRIES];
  logic [ADDR_W-1:0]  base_mem [ENTRIES];
  logic [1:0]         size_mem [ENTRIES];
  logic [ADDR_W-1:0]  emask    [ENTRIES];
  logic [ENTRIES-1:0] match;

  logic [IDX_W-1:0]   victim_q;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   tgt;
  logic               full;
  logic               do_ins;
  logic [63:0]        ins_m64;
  logic [ADDR_W-1:0]  ins_mask;

  // Per-entry compare against the size-masked linear address.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [63:0] m64;
    assign m64      = page_mask(size_mem[g]);
    assign emask[g] = m64[ADDR_W-1:0];
    assign match[g] = vld[g] && ((lk_addr & ~emask[g]) == tag_mem[g]);
  end

  // Lowest matching index wins.
  always_comb begin
    lk_hit  = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit  = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    lk_pa = base_mem[hit_idx] | (lk_addr & emask[hit_idx]);
  end

  // Free-list order: ascending index.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign full     = &vld;
  assign tgt      = full ? victim_q : free_idx;
  assign do_ins   = ins_valid && !flush;
  assign ins_m64  = page_mask(ins_size);
  assign ins_mask = ins_m64[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld      <= '0;
      victim_q <= '0;
    end else if (do_ins) begin
      vld[tgt] <= 1'b1;
      if (full) victim_q <= (victim_q == LAST_IDX) ? '0 : victim_q + 1'b1;
    end
  end

  // Payload arrays carry no reset.
  always_ff @(posedge clk) begin
    if (do_ins) begin
      tag_mem[tgt]  <= ins_va & ~ins_mask;
      base_mem[tgt] <= ins_pa & ~ins_mask;
      size_mem[tgt] <= ins_size;
    end
  end

endmodule

// File: rtl/addr_xlate.sv
`timescale 1ns/1ps
module addr_xlate
  import xlt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic              req_write,
  input  logic              pe,
  input  logic              pg,
  input  logic              lma,
  input  logic              cs_long,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              seg_writable,
  input  logic              seg_expdown,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_va,
  input  logic [ADDR_W-1:0] ins_pa,
  input  logic [1:0]        ins_size,
  input  logic              flush,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [1:0]        rsp_fault
);

  logic              long64;
  logic [ADDR_W-1:0] linear;
  logic              gp;
  logic              hit;
  logic [ADDR_W-1:0] hit_pa;
  flt_e              nxt_flt;
  flt_e              flt_q;
  logic [ADDR_W-1:0] nxt_pa;

  assign long64 = lma && cs_long;

  xlt_segchk #(.ADDR_W(ADDR_W)) u_seg (
    .offset   (req_va),
    .is_write (req_write),
    .long64   (long64),
    .base     (seg_base),
    .limit    (seg_limit),
    .writable (seg_writable),
    .expdown  (seg_expdown),
    .linear   (linear),
    .gp       (gp)
  );

  xlt_tlb #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_tlb (
    .clk       (clk),
    .rst       (rst),
    .lk_addr   (linear),
    .lk_hit    (hit),
    .lk_pa     (hit_pa),
    .ins_valid (ins_valid),
    .ins_va    (ins_va),
    .ins_pa    (ins_pa),
    .ins_size  (ins_size),
    .flush     (flush)
  );

  always_comb begin
    nxt_flt = FLT_NONE;
    nxt_pa  = '0;
    if (!pe) begin
      nxt_pa = req_va;
    end else if (gp) begin
      nxt_flt = FLT_GP;
    end else if (!pg) begin
      nxt_pa = linear;
    end else if (hit) begin
      nxt_pa = hit_pa;
    end else begin
      nxt_flt = FLT_MISS;
      nxt_pa  = linear;
    end
    if (!req_valid) begin
      nxt_flt = FLT_NONE;
      nxt_pa  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      flt_q     <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_pa    <= nxt_pa;
      flt_q     <= nxt_flt;
    end
  end

  assign rsp_fault = flt_q;

endmodule

// File: rtl/xlt_chk.sv
`timescale 1ns/1ps
module xlt_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_va,
  input logic              req_write,
  input logic              pe,
  input logic              pg,
  input logic              lma,
  input logic              cs_long,
  input logic [ADDR_W-1:0] seg_base,
  input logic              seg_writable,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic [1:0]        rsp_fault
);

  logic [ADDR_W-1:0] lin_sum;
  assign lin_sum = req_va + seg_base;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_fault == 2'b00 && rsp_pa == '0)); // R1

  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_fault != 2'b11); // R2

  AST_REAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !pe) |=> (rsp_fault == 2'b00 && rsp_pa == $past(req_va))); // R3

  AST_WRITE_PROT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pe && !(lma && cs_long) && req_write && !seg_writable)
      |=> rsp_fault == 2'b01); // R4

  AST_LONG_NO_GP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pe && lma && cs_long) |=> rsp_fault != 2'b01); // R7

  AST_PGOFF_LINEAR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pe && !pg && lma && cs_long)
      |=> (rsp_fault == 2'b00 && rsp_pa == $past(lin_sum))); // R8

endmodule

bind addr_xlate xlt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_va       (req_va),
  .req_write    (req_write),
  .pe           (pe),
  .pg           (pg),
  .lma          (lma),
  .cs_long      (cs_long),
  .seg_base     (seg_base),
  .seg_writable (seg_writable),
  .rsp_valid    (rsp_valid),
  .rsp_pa       (rsp_pa),
  .rsp_fault    (rsp_fault)
);

// File: tb/tb_addr_xlate.sv
`timescale 1ns/1ps
module tb_addr_xlate;

  localparam int AW = 32;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_va = '0;
  logic          req_write = 1'b0;
  logic          pe = 1'b0, pg = 1'b0, lma = 1'b0, cs_long = 1'b0;
  logic [AW-1:0] seg_base = '0, seg_limit = '1;
  logic          seg_writable = 1'b1, seg_expdown = 1'b0;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_va = '0, ins_pa = '0;
  logic [1:0]    ins_size = 2'd0;
  logic          flush = 1'b0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_pa;
  logic [1:0]    rsp_fault;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  addr_xlate #(.ADDR_W(AW), .ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .pe(pe), .pg(pg), .lma(lma), .cs_long(cs_long),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_writable(seg_writable),
    .seg_expdown(seg_expdown), .ins_valid(ins_valid), .ins_va(ins_va),
    .ins_pa(ins_pa), .ins_size(ins_size), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // One request; results sampled just after the registering edge.
  task automatic access(input logic [AW-1:0] va, input logic wr,
                        output logic [AW-1:0] pa, output logic [1:0] f);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 1);
    pa = rsp_pa; f = rsp_fault;
  endtask

  task automatic expect_ok(input string rq, input logic [AW-1:0] va, input logic wr,
                           input logic [AW-1:0] exp_pa);
    logic [AW-1:0] pa; logic [1:0] f;
    access(va, wr, pa, f);
    chk({rq, " fault"}, {30'd0, f}, 0);
    chk({rq, " pa"}, pa, exp_pa);
  endtask

  task automatic expect_flt(input string rq, input logic [AW-1:0] va, input logic wr,
                            input logic [1:0] exp_f);
    logic [AW-1:0] pa; logic [1:0] f;
    access(va, wr, pa, f);
    chk({rq, " fault"}, {30'd0, f}, {30'd0, exp_f});
  endtask

  task automatic expect_miss(input string rq, input logic [AW-1:0] va, input logic [AW-1:0] lin);
    logic [AW-1:0] pa; logic [1:0] f;
    access(va, 1'b0, pa, f);
    chk({rq, " miss fault"}, {30'd0, f}, 2);
    chk({rq, " miss linear"}, pa, lin);
  endtask

  task automatic insert(input logic [AW-1:0] va, input logic [AW-1:0] pa, input logic [1:0] sz);
    @(negedge clk);
    ins_valid = 1'b1; ins_va = va; ins_pa = pa; ins_size = sz;
    @(posedge clk); #1;
    ins_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {31'd0, rsp_valid}, 0);
    chk("R1 reset fault", {30'd0, rsp_fault}, 0);
    chk("R1 reset pa", rsp_pa, 0);
  endtask

  task automatic t_real();
    pe = 0; pg = 1; seg_base = 32'h0001_0000; seg_writable = 0; seg_limit = 0;
    expect_ok("R3 real", 32'h1234_5678, 1'b1, 32'h1234_5678);
    @(posedge clk); #1;
    chk("R1 idle valid", {31'd0, rsp_valid}, 0);
    chk("R1 idle fault", {30'd0, rsp_fault}, 0);
  endtask

  task automatic t_wrprot();
    pe = 1; pg = 0; lma = 0; cs_long = 0; seg_base = 32'h0001_0000;
    seg_limit = '1; seg_expdown = 0; seg_writable = 0;
    expect_flt("R4 write ro", 32'h100, 1'b1, 2'b01);
    expect_ok("R8 read ro", 32'h100, 1'b0, 32'h0001_0100);
    seg_writable = 1;
    expect_ok("R4 write rw", 32'h100, 1'b1, 32'h0001_0100);
  endtask

  task automatic t_limit();
    seg_base = 0; seg_limit = 32'h1000; seg_expdown = 0;
    expect_ok("R5 at limit", 32'h1000, 1'b0, 32'h1000);
    expect_flt("R5 above limit", 32'h1001, 1'b0, 2'b01);
  endtask

  task automatic t_expdown();
    seg_expdown = 1;
    expect_flt("R6 at limit", 32'h1000, 1'b0, 2'b01);
    expect_flt("R6 below limit", 32'h0, 1'b0, 2'b01);
    expect_ok("R6 above limit", 32'h1001, 1'b0, 32'h1001);
    seg_expdown = 0;
  endtask

  task automatic t_long();
    seg_base = 32'h0000_4000; seg_limit = 0; seg_writable = 0;
    lma = 1; cs_long = 0;
    expect_flt("R7 lma only", 32'h5000, 1'b1, 2'b01);
    cs_long = 1;
    expect_ok("R7 64-bit", 32'h5000, 1'b1, 32'h0000_9000);
    seg_base = 32'hFFFF_F000;
    expect_ok("R8 wrap", 32'h2000, 1'b0, 32'h0000_1000);
    seg_base = 0; seg_writable = 1; seg_limit = '1;
  endtask

  task automatic t_pages();
    pg = 1;
    do_flush();
    expect_miss("R9 empty", 32'h0040_3ABC, 32'h0040_3ABC);
    insert(32'h0040_3123, 32'h7700_0FFF, 2'd0);
    expect_ok("R10 4K hit", 32'h0040_3ABC, 1'b0, 32'h7700_0ABC);
    expect_miss("R10 4K neighbour", 32'h0040_4ABC, 32'h0040_4ABC);
    insert(32'h0160_0000, 32'h4000_0000, 2'd1);
    expect_ok("R10 2M hit", 32'h017F_FFFF, 1'b0, 32'h401F_FFFF);
    insert(32'h0800_0000, 32'h8000_0000, 2'd2);
    expect_ok("R10 4M hit", 32'h083A_BCDE, 1'b0, 32'h803A_BCDE);
    expect_miss("R10 4M beyond", 32'h0840_0000, 32'h0840_0000);
    seg_base = 32'h0000_1000;
    expect_ok("R10 linear lookup", 32'h0040_2004, 1'b0, 32'h7700_0004);
    expect_miss("R9 linear carried", 32'h0000_0010, 32'h0000_1010);
    seg_base = 0;
  endtask

  task automatic t_replace();
    do_flush();
    for (int k = 0; k < N; k++) insert(AW'((k + 1) << 12), AW'((k + 32'h100) << 12), 2'd0);
    for (int k = 0; k < N; k++)
      expect_ok("R11 full hit", AW'(((k + 1) << 12) | 12'h44), 1'b0, AW'(((k + 32'h100) << 12) | 12'h44));
    insert(32'h0002_0000, 32'h0030_0000, 2'd0);
    expect_miss("R11 oldest evicted", 32'h0000_1000, 32'h0000_1000);
    expect_ok("R11 second kept", 32'h0000_2008, 1'b0, 32'h0010_1008);
    expect_ok("R11 new present", 32'h0002_0008, 1'b0, 32'h0030_0008);
    insert(32'h0002_1000, 32'h0031_0000, 2'd0);
    expect_miss("R11 next evicted", 32'h0000_2000, 32'h0000_2000);
    expect_ok("R11 third kept", 32'h0000_3000, 1'b0, 32'h0010_2000);
    expect_ok("R11 first new kept", 32'h0002_0000, 1'b0, 32'h0030_0000);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1; ins_valid = 1'b1; ins_va = 32'h0005_0000; ins_pa = 32'h0006_0000; ins_size = 2'd0;
    @(posedge clk); #1;
    flush = 1'b0; ins_valid = 1'b0;
    expect_miss("R12 flushed", 32'h0000_3000, 32'h0000_3000);
    expect_miss("R12 insert dropped", 32'h0005_0000, 32'h0005_0000);
    insert(32'h0005_0000, 32'h0006_0000, 2'd0);
    expect_ok("R12 insert next cycle", 32'h0005_0abc, 1'b0, 32'h0006_0abc);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_real();
    t_wrprot();
    t_limit();
    t_expdown();
    t_long();
    t_pages();
    t_replace();
    t_flush();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule